// File: doc/BRIEF.md
# Deep-Sleep Timer Controller

This block puts a radio into deep sleep and brings it back out on a schedule kept by a slow tick counter. The counter normally steps at 32.768 kHz. The step comes in as a one-clock strobe in the system clock domain. Software writes an absolute tick count at which sleep begins and another at which it ends. Both compares are modulo the counter width, so targets that lie past a wrap still work. Sleep begins only while the timer, the clock-request permission and the sleep arm are all set.

While asleep, the oscillator enable is held low. It comes back a programmable number of ticks before the wake count, so the oscillator can settle. Sleep ends at the wake count, but only once the oscillator reports ready. At that point a finished flag is raised and held for a fixed number of ticks. The span between the two targets is converted to microseconds and added to an event-time register. A sleep compare that matches while the finished flag is up is remembered and carried out as soon as the flag drops. If the wake target equals the sleep target, the block sleeps for one full turn of the counter.

Access is through a simple register port: a write strobe with address and data, and a combinational read by address.

Top module: `dsleep_ctrl`

## Requirements
- R1: The tick counter (address 4, read-only) advances by one per `tick_i` strobe only while CTRL (address 0) bit 0, timer enable, is 1. It resets to 0.
- R2: With CTRL bits 0, 1 and 2 all set (value 7), `sleep_o` rises on the tick that brings the counter to the sleep target (address 1), and not earlier.
- R3: No sleep begins while CTRL bit 1, clock-request permission, is 0.
- R4: No sleep begins while CTRL bit 2, sleep arm, is 0.
- R5: While asleep, `osc_en_o` is 0 until the counter reaches the wake target (address 2) minus the oscillator lead (address 3), and is 1 from then on. `sleep_o` falls only after the wake target has been reached and `osc_rdy_i` is 1.
- R6: `finished_o` is 1 from the cycle after `sleep_o` falls until the second tick after that, and then clears by itself.
- R7: On wake, the event-time register (address 5, read and write) grows by `(span*15625)>>9`. Here span is (wake target minus sleep target) modulo 2^CNT_W, and a difference of 0 counts as 2^CNT_W.
- R8: With the wake target equal to the sleep target, sleep lasts exactly 2^CNT_W ticks.
- R9: A sleep compare that matches while `finished_o` is 1 sets the pending bit, FLAGS (address 6) bit 2. It does not start sleep at once. Sleep starts once the finished flag clears.
- R10: FLAGS bit 1, the wake flag, is set on every wake. It is cleared only by writing 1 to that bit; writing 0 leaves it set.
- R11: Writes to the read-only tick counter address have no effect on its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock strobe per slow tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| osc_rdy_i | input | 1 | Oscillator reports stable |
| osc_en_o | output | 1 | Oscillator enable request |
| sleep_o | output | 1 | Deep sleep in effect |
| finished_o | output | 1 | Post-wake finished window |

## Verification
The bench builds the block with an 8-bit tick counter in place of the default 24 bits. This lets a full counter turn, the automatic wake when both targets are equal, be stepped through in a few hundred ticks. It also puts the full-span microsecond credit (256 ticks, 7812 µs) within reach. The finished window keeps its default of 2 ticks, so a sleep compare can be placed inside it to exercise the deferred entry. The oscillator-ready input is held low across one wake to expose the wait.

// File: rtl/dsl_pkg.sv
// Shared definitions for the deep-sleep timer controller.
// Assumes the register port addresses are 3 bits wide.
package dsl_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_WAKING = 2'd2
    } dsl_state_e;

    localparam logic [2:0] A_CTRL     = 3'd0;
    localparam logic [2:0] A_SLEEP_AT = 3'd1;
    localparam logic [2:0] A_WAKE_AT  = 3'd2;
    localparam logic [2:0] A_OSC_LEAD = 3'd3;
    localparam logic [2:0] A_TICKS    = 3'd4;
    localparam logic [2:0] A_EVTIME   = 3'd5;
    localparam logic [2:0] A_FLAGS    = 3'd6;

    localparam int B_TMR_EN = 0;
    localparam int B_CLKREQ = 1;
    localparam int B_ARM    = 2;

    localparam int F_FIN  = 0;
    localparam int F_WOKE = 1;
    localparam int F_PEND = 2;

    localparam int US_MUL   = 15625;
    localparam int US_SHIFT = 9;
    localparam int US_MUL_W = 14;
endpackage

// File: rtl/dsl_tick_counter.sv
// Free-running slow tick counter.
// Steps on tick_i while enabled, wraps modulo 2^CNT_W.
// step_o pulses in the cycle after each change, when cnt_o already holds the new value.
module dsl_tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             step_o
);
    // Count enabled ticks and flag each new value for one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            step_o <= 1'b0;
        end else begin
            step_o <= en_i && tick_i;
            if (en_i && tick_i) cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/dsl_span_conv.sv
// Converts a tick span to microseconds: (span*15625)>>9.
// A zero difference means a full counter turn of 2^CNT_W ticks.
// Purely combinational.
module dsl_span_conv
    import dsl_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int EVT_W = 32
) (
    input  logic [CNT_W-1:0] diff_i,
    output logic [EVT_W-1:0] us_o
);
    localparam int PROD_W = CNT_W + 1 + US_MUL_W;

    logic [CNT_W:0]    span;
    logic [PROD_W-1:0] prod;

    // Widen the span, multiply by the tick-to-microsecond ratio, then scale down
    always_comb begin
        span = (diff_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, diff_i};
        prod = PROD_W'(span) * PROD_W'(US_MUL);
        us_o = EVT_W'(prod >> US_SHIFT);
    end
endmodule

// File: rtl/dsl_sleep_seq.sv
// Sleep sequencer: enters sleep on the sleep compare and leaves on the wake compare.
// Leaving also waits for oscillator ready. After a wake it holds a finished window
// of FIN_TICKS ticks; a sleep compare inside that window is deferred.
// Assumes step_i marks the cycle in which cnt_i has just taken a new value.
module dsl_sleep_seq
    import dsl_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int FIN_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] sleep_at_i,
    input  logic [CNT_W-1:0] wake_at_i,
    input  logic [CNT_W-1:0] lead_i,
    input  logic             gate_ok_i,
    input  logic             osc_rdy_i,
    output logic             sleep_o,
    output logic             osc_en_o,
    output logic             fin_o,
    output logic             pend_o,
    output logic             wake_evt_o
);
    localparam int FW = $clog2(FIN_TICKS + 1);

    dsl_state_e      st;
    logic [FW-1:0]   fcnt;
    logic            sleep_hit;
    logic            wake_hit;
    logic            lead_hit;
    logic [CNT_W-1:0] lead_pt;

    // Compare events, qualified by a fresh counter value
    always_comb begin
        lead_pt   = wake_at_i - lead_i;
        sleep_hit = step_i && (cnt_i == sleep_at_i);
        wake_hit  = step_i && (cnt_i == wake_at_i);
        lead_hit  = step_i && (cnt_i == lead_pt);
    end

    assign sleep_o = (st != ST_AWAKE);

    // State, oscillator request, finished window and deferred entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_AWAKE;
            osc_en_o   <= 1'b1;
            fin_o      <= 1'b0;
            fcnt       <= '0;
            pend_o     <= 1'b0;
            wake_evt_o <= 1'b0;
        end else begin
            wake_evt_o <= 1'b0;
            if (fin_o && step_i) begin
                if (fcnt == FW'(FIN_TICKS - 1)) begin
                    fin_o <= 1'b0;
                    fcnt  <= '0;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end
            case (st)
                ST_AWAKE: begin
                    if (!gate_ok_i) begin
                        pend_o <= 1'b0;
                    end else if (sleep_hit && fin_o) begin
                        pend_o <= 1'b1;
                    end else if (sleep_hit || (pend_o && !fin_o)) begin
                        st       <= ST_SLEEP;
                        osc_en_o <= 1'b0;
                        pend_o   <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit) begin
                        st       <= ST_WAKING;
                        osc_en_o <= 1'b1;
                    end else if (lead_hit) begin
                        osc_en_o <= 1'b1;
                    end
                end
                ST_WAKING: begin
                    if (osc_rdy_i) begin
                        st         <= ST_AWAKE;
                        fin_o      <= 1'b1;
                        fcnt       <= '0;
                        wake_evt_o <= 1'b1;
                    end
                end
                default: st <= ST_AWAKE;
            endcase
        end
    end
endmodule

// File: rtl/dsleep_ctrl.sv
// Deep-sleep timer controller top: register file, tick counter, sleep sequencer
// and event-time credit.
// Assumes CNT_W and EVT_W do not exceed DATA_W, and that tick_i is a one-clock strobe.
module dsleep_ctrl
    import dsl_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int EVT_W     = 32,
    parameter int LEAD_W    = 8,
    parameter int FIN_TICKS = 2,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              osc_rdy_i,
    output logic              osc_en_o,
    output logic              sleep_o,
    output logic              finished_o
);
    logic              tmr_en;
    logic              clkreq;
    logic              arm;
    logic [CNT_W-1:0]  sleep_at;
    logic [CNT_W-1:0]  wake_at;
    logic [LEAD_W-1:0] osc_lead;
    logic [EVT_W-1:0]  evtime;
    logic              woke;
    logic [CNT_W-1:0]  cnt;
    logic              step;
    logic              pend;
    logic              wake_evt;
    logic [EVT_W-1:0]  credit;
    logic              gate_ok;

    assign gate_ok = tmr_en && clkreq && arm;

    dsl_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tmr_en),
        .tick_i (tick_i),
        .cnt_o  (cnt),
        .step_o (step)
    );

    dsl_sleep_seq #(.CNT_W(CNT_W), .FIN_TICKS(FIN_TICKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .cnt_i      (cnt),
        .sleep_at_i (sleep_at),
        .wake_at_i  (wake_at),
        .lead_i     (CNT_W'(osc_lead)),
        .gate_ok_i  (gate_ok),
        .osc_rdy_i  (osc_rdy_i),
        .sleep_o    (sleep_o),
        .osc_en_o   (osc_en_o),
        .fin_o      (finished_o),
        .pend_o     (pend),
        .wake_evt_o (wake_evt)
    );

    dsl_span_conv #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_conv (
        .diff_i (wake_at - sleep_at),
        .us_o   (credit)
    );

    // Software-written control and target registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_en   <= 1'b0;
            clkreq   <= 1'b0;
            arm      <= 1'b0;
            sleep_at <= '0;
            wake_at  <= '0;
            osc_lead <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL: begin
                    tmr_en <= wr_data_i[B_TMR_EN];
                    clkreq <= wr_data_i[B_CLKREQ];
                    arm    <= wr_data_i[B_ARM];
                end
                A_SLEEP_AT: sleep_at <= wr_data_i[CNT_W-1:0];
                A_WAKE_AT:  wake_at  <= wr_data_i[CNT_W-1:0];
                A_OSC_LEAD: osc_lead <= wr_data_i[LEAD_W-1:0];
                default: ;
            endcase
        end
    end

    // Event time: credited on wake, otherwise loadable by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evtime <= '0;
        end else if (wake_evt) begin
            evtime <= evtime + credit;
        end else if (wr_en_i && wr_addr_i == A_EVTIME) begin
            evtime <= wr_data_i[EVT_W-1:0];
        end
    end

    // Wake flag: set by hardware, write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            woke <= 1'b0;
        end else if (wake_evt) begin
            woke <= 1'b1;
        end else if (wr_en_i && wr_addr_i == A_FLAGS && wr_data_i[F_WOKE]) begin
            woke <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL: begin
                rd_data_o[B_TMR_EN] = tmr_en;
                rd_data_o[B_CLKREQ] = clkreq;
                rd_data_o[B_ARM]    = arm;
            end
            A_SLEEP_AT: rd_data_o[CNT_W-1:0]  = sleep_at;
            A_WAKE_AT:  rd_data_o[CNT_W-1:0]  = wake_at;
            A_OSC_LEAD: rd_data_o[LEAD_W-1:0] = osc_lead;
            A_TICKS:    rd_data_o[CNT_W-1:0]  = cnt;
            A_EVTIME:   rd_data_o[EVT_W-1:0]  = evtime;
            A_FLAGS: begin
                rd_data_o[F_FIN]  = finished_o;
                rd_data_o[F_WOKE] = woke;
                rd_data_o[F_PEND] = pend;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dsleep_ctrl_chk.sv
// Property checker for the deep-sleep timer controller, bound into every instance.
module dsleep_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_o,
    input logic finished_o,
    input logic osc_en_o,
    input logic osc_rdy_i,
    input logic gate_ok_i
);
    AST_WAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> $past(osc_rdy_i)); // R5

    AST_OSC_OFF_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> !osc_en_o); // R5

    AST_FIN_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> finished_o); // R6

    AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(gate_ok_i)); // R3

    AST_NO_ENTRY_IN_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> !$past(finished_o)); // R9
endmodule

bind dsleep_ctrl dsleep_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_o    (sleep_o),
    .finished_o (finished_o),
    .osc_en_o   (osc_en_o),
    .osc_rdy_i  (osc_rdy_i),
    .gate_ok_i  (gate_ok)
);

// File: tb/dsleep_ctrl_test.sv
`timescale 1ns/1ps
module dsleep_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = 3'd0;
    logic [31:0] wr_data_i = 32'd0;
    logic [2:0]  rd_addr_i = 3'd0;
    logic [31:0] rd_data_o;
    logic        osc_rdy_i = 1'b1;
    logic        osc_en_o;
    logic        sleep_o;
    logic        finished_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dsleep_ctrl #(.CNT_W(8), .EVT_W(32), .LEAD_W(8), .FIN_TICKS(2), .DATA_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .osc_rdy_i(osc_rdy_i), .osc_en_o(osc_en_o),
        .sleep_o(sleep_o), .finished_o(finished_o)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr_i = a;
        #1 d = rd_data_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 reset sleep", {31'd0, sleep_o}, 32'd0);
        check("R6 reset finished", {31'd0, finished_o}, 32'd0);
        check("R5 reset osc_en", {31'd0, osc_en_o}, 32'd1);
        rd(3'd4, v); check("R1 reset count", v, 32'd0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(3'd0, 32'd0); ticks(3);
        rd(3'd4, v); check("R1 disabled count", v, 32'd0);
        wr(3'd0, 32'd3); ticks(3);
        rd(3'd4, v); check("R1 enabled count", v, 32'd3);
    endtask

    task automatic t_gating();
        logic [31:0] v;
        wr(3'd1, 32'd5); wr(3'd0, 32'd5); ticks(3);
        rd(3'd4, v); check("R3 count passed target", v, 32'd6);
        check("R3 no sleep without clkreq", {31'd0, sleep_o}, 32'd0);
        wr(3'd1, 32'd8); wr(3'd0, 32'd3); ticks(3);
        check("R4 no sleep without arm", {31'd0, sleep_o}, 32'd0);
    endtask

    task automatic t_sleep_wake();
        logic [31:0] v;
        wr(3'd5, 32'd1000);
        wr(3'd1, 32'd13); wr(3'd2, 32'd33); wr(3'd3, 32'd3);
        wr(3'd0, 32'd7);
        ticks(3);
        check("R2 not before target", {31'd0, sleep_o}, 32'd0);
        ticks(1);
        check("R2 sleep at target", {31'd0, sleep_o}, 32'd1);
        check("R5 osc off asleep", {31'd0, osc_en_o}, 32'd0);
        ticks(16);
        check("R5 osc off before lead", {31'd0, osc_en_o}, 32'd0);
        ticks(1);
        check("R5 osc on at lead", {31'd0, osc_en_o}, 32'd1);
        check("R5 still asleep at lead", {31'd0, sleep_o}, 32'd1);
        osc_rdy_i = 1'b0;
        ticks(3);
        check("R5 waits for ready", {31'd0, sleep_o}, 32'd1);
        @(negedge clk) osc_rdy_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 wake after ready", {31'd0, sleep_o}, 32'd0);
        check("R6 finished after wake", {31'd0, finished_o}, 32'd1);
        rd(3'd5, v); check("R7 credit span 20", v, 32'd1610);
        ticks(1);
        check("R6 finished after one tick", {31'd0, finished_o}, 32'd1);
        ticks(1);
        check("R6 finished cleared", {31'd0, finished_o}, 32'd0);
    endtask

    task automatic t_woke_flag();
        logic [31:0] v;
        rd(3'd6, v); check("R10 woke set", {31'd0, v[1]}, 32'd1);
        wr(3'd6, 32'd0);
        rd(3'd6, v); check("R10 write 0 keeps", {31'd0, v[1]}, 32'd1);
        wr(3'd6, 32'd2);
        rd(3'd6, v); check("R10 write 1 clears", {31'd0, v[1]}, 32'd0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        // count is 35 here
        wr(3'd1, 32'd40); wr(3'd2, 32'd40); wr(3'd5, 32'd0);
        ticks(5);
        check("R8 asleep at target", {31'd0, sleep_o}, 32'd1);
        ticks(255);
        check("R8 asleep before full turn", {31'd0, sleep_o}, 32'd1);
        ticks(1);
        check("R8 awake after full turn", {31'd0, sleep_o}, 32'd0);
        rd(3'd5, v); check("R7 full-turn credit", v, 32'd7812);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        // count 40, finished window open
        wr(3'd1, 32'd41); wr(3'd2, 32'd45); wr(3'd3, 32'd0);
        ticks(1);
        check("R9 no entry in window", {31'd0, sleep_o}, 32'd0);
        rd(3'd6, v); check("R9 pending set", {31'd0, v[2]}, 32'd1);
        ticks(1);
        check("R9 deferred entry", {31'd0, sleep_o}, 32'd1);
        ticks(3);
        check("R9 wake after deferred", {31'd0, sleep_o}, 32'd0);
        rd(3'd5, v); check("R7 credit span 4", v, 32'd7934);
    endtask

    task automatic t_ro();
        logic [31:0] v;
        wr(3'd4, 32'd0);
        rd(3'd4, v); check("R11 count write ignored", v, 32'd45);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_gating();
        t_sleep_wake();
        t_woke_flag();
        t_wrap();
        t_pending();
        t_ro();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule